// File: doc/BRIEF.md
# Paired Breakpoint Trigger Matcher

This block holds a bank of debug triggers that watch the address and data of memory accesses or fetches and flag a breakpoint when one matches. The triggers are grouped in fixed pairs. A pair can be linked so that it raises a hit only when both of its members match the same probe. Each trigger keeps its own settings: enable, match kind, operand select, trap timing, action and a 64-bit compare value. A chain flag is kept per pair.

Settings arrive through a single write port carrying a valid strobe, a trigger index and the settings word. The write takes effect from the following clock cycle. The probe side is combinational. In the same cycle that a probe is presented, the block returns a per-trigger hit vector, an any-hit flag, a flag saying the trap belongs to the next instruction rather than the current one, and the OR of the action bits of the triggers that fired.

Top module: `trig_match_top`

## Requirements
- R1: After reset every trigger is disabled and every pair is unchained, so no probe produces a hit until a trigger is written.
- R2: A write with `cfg_we` high and `cfg_idx` below the trigger count updates only the indexed trigger, visible from the next cycle. A write with `cfg_idx` at or above the trigger count changes nothing. The chain flag of pair i is taken only from writes to trigger 2i (even index); the chain field of a write to an odd index is discarded.
- R3: Match kind encodings: 0 matches on equality. 1 matches a naturally aligned power-of-two region, where the compare value's trailing ones plus one give the number of ignored low bits. 2 matches when the operand is greater than or equal to the compare value (unsigned). 3 matches when the operand is below it.
- R4: With select 0 a trigger compares the address input; with select 1 it compares the data input.
- R5: In an unchained pair each enabled trigger fires on its own match.
- R6: In a chained pair both triggers fire together, and only when both match the same probe.
- R7: A chained pair whose two members have different timing values never fires.
- R8: A chained pair never fires on a store probe (`probe_store` high). A data-select trigger never matches on a load probe (`probe_load` high).
- R9: `any_hit` is high exactly when at least one bit of `hit_vec` is high, and bit k of `hit_vec` belongs to trigger k.
- R10: Timing 0 means a trap at the current instruction, and timing 1 a trap at the next one. `trap_next` is high when some trigger fires and none of the fired triggers has timing 0.
- R11: With `hit_clear` high, or with `probe_valid` low, all hit outputs are zero in that cycle.
- R12: `trap_action` is the OR of the action bits of the triggers that fired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Settings write strobe |
| cfg_idx | input | 4 | Index of the trigger being written |
| cfg_en | input | 1 | Trigger enable |
| cfg_mtype | input | 2 | Match kind (0 equal, 1 aligned region, 2 at-or-above, 3 below) |
| cfg_sel | input | 1 | Operand select: 0 address, 1 data |
| cfg_timing | input | 1 | 0 trap at current, 1 trap at next instruction |
| cfg_action | input | 1 | Action bit reported on fire |
| cfg_chain | input | 1 | Pair chain flag (used on even-index writes only) |
| cfg_value | input | 64 | Compare value |
| probe_valid | input | 1 | A probe is present this cycle |
| probe_store | input | 1 | The probe is a store |
| probe_load | input | 1 | The probe is a load |
| probe_addr | input | 64 | Probe address |
| probe_data | input | 64 | Probe data |
| hit_clear | input | 1 | Forces all hit outputs to zero |
| hit_vec | output | 10 | Per-trigger fire bits |
| any_hit | output | 1 | OR of the fire bits |
| trap_next | output | 1 | Trap applies to the next instruction |
| trap_action | output | 1 | OR of the action bits of fired triggers |

## Verification
The bench builds the block with its default parameters: five pairs, ten triggers and a 64-bit compare width. With these values the unused index range 10 to 15 of the 4-bit index is available to test ignored writes. The full 64-bit width is also available, so an all-ones compare value under the aligned-region kind can be shown to cover the whole space. Ten triggers leave room for chained and unchained pairs to sit side by side, so a probe can hit several pairs at once and mix timings across pairs.

// File: rtl/trig_pkg.sv
package trig_pkg;

  typedef enum logic [1:0] {
    MT_EQ    = 2'd0,
    MT_NAPOT = 2'd1,
    MT_GE    = 2'd2,
    MT_LT    = 2'd3
  } match_kind_e;

  typedef struct packed {
    logic        en;
    match_kind_e mtype;
    logic        sel;
    logic        timing;
    logic        action;
  } trig_ctl_t;

endpackage

// File: rtl/trig_bank.sv
module trig_bank
  import trig_pkg::*;
#(
  parameter int NUM_TRIG  = 10,
  parameter int NUM_PAIRS = 5,
  parameter int DW        = 64,
  parameter int IDXW      = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_we,
  input  logic [IDXW-1:0]               cfg_idx,
  input  trig_ctl_t                     cfg_ctl,
  input  logic                          cfg_chain,
  input  logic [DW-1:0]                 cfg_value,
  output trig_ctl_t [NUM_TRIG-1:0]      ctl_o,
  output logic [NUM_TRIG-1:0][DW-1:0]   val_o,
  output logic [NUM_PAIRS-1:0]          chain_o
);

  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NUM_TRIG - 1);

  trig_ctl_t [NUM_TRIG-1:0]    ctl_q;
  logic [NUM_TRIG-1:0][DW-1:0] val_q;
  logic [NUM_PAIRS-1:0]        chain_q;
  logic                        idx_ok;
  logic [NUM_TRIG-1:0]         en_vec;

  assign idx_ok = cfg_idx <= LAST_IDX;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= '0;
      val_q   <= '0;
      chain_q <= '0;
    end else if (cfg_we && idx_ok) begin
      ctl_q[cfg_idx] <= cfg_ctl;
      val_q[cfg_idx] <= cfg_value;
      if (!cfg_idx[0]) chain_q[cfg_idx[IDXW-1:1]] <= cfg_chain;
    end
  end

  always_comb begin
    for (int k = 0; k < NUM_TRIG; k++) en_vec[k] = ctl_q[k].en;
  end

  assign ctl_o   = ctl_q;
  assign val_o   = val_q;
  assign chain_o = chain_q;

  // R1: the cycle after reset nothing is enabled and no pair is linked
  p_reset_off_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (en_vec == '0 && chain_q == '0));

  // R2: a valid write lands in the indexed slot
  p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && idx_ok) |=> (ctl_q[$past(cfg_idx)] == $past(cfg_ctl)
                            && val_q[$past(cfg_idx)] == $past(cfg_value)));

endmodule

// File: rtl/trig_cmp.sv
module trig_cmp
  import trig_pkg::*;
#(
  parameter int DW = 64
) (
  input  trig_ctl_t      ctl,
  input  logic [DW-1:0]  value,
  input  logic [DW-1:0]  addr,
  input  logic [DW-1:0]  data,
  input  logic           valid,
  input  logic           is_load,
  output logic           hit
);

  logic [DW-1:0] opnd;
  logic [DW-1:0] care_n;
  logic          m;

  always_comb begin
    opnd   = ctl.sel ? data : addr;
    care_n = value ^ (value + DW'(1));
    unique case (ctl.mtype)
      MT_EQ:    m = (opnd == value);
      MT_NAPOT: m = ((opnd & ~care_n) == (value & ~care_n));
      MT_GE:    m = (opnd >= value);
      default:  m = (opnd < value);
    endcase
    hit = valid && ctl.en && !(ctl.sel && is_load) && m;
  end

endmodule

// File: rtl/trig_pair.sv
module trig_pair (
  input  logic clk,
  input  logic rst,
  input  logic raw_a,
  input  logic raw_b,
  input  logic tim_a,
  input  logic tim_b,
  input  logic chain,
  input  logic is_store,
  output logic fire_a,
  output logic fire_b
);

  logic both;

  always_comb begin
    both = raw_a && raw_b && (tim_a == tim_b) && !is_store;
    if (chain) begin
      fire_a = both;
      fire_b = both;
    end else begin
      fire_a = raw_a;
      fire_b = raw_b;
    end
  end

  // R6: a linked pair fires only when both members match
  p_chain_needs_both_r6: assert property (@(posedge clk) disable iff (rst)
    (chain && (fire_a || fire_b)) |-> (raw_a && raw_b));

  // R7: differing timing in a linked pair silences it
  p_timing_split_r7: assert property (@(posedge clk) disable iff (rst)
    (chain && (tim_a != tim_b)) |-> !(fire_a || fire_b));

  // R8: a linked pair stays silent on stores
  p_store_chain_r8: assert property (@(posedge clk) disable iff (rst)
    (chain && is_store) |-> !(fire_a || fire_b));

endmodule

// File: rtl/trig_match_top.sv
module trig_match_top
  import trig_pkg::*;
#(
  parameter int NUM_PAIRS = 5,
  parameter int DW        = 64,
  localparam int NUM_TRIG = 2 * NUM_PAIRS,
  localparam int IDXW     = $clog2(NUM_TRIG)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [IDXW-1:0]     cfg_idx,
  input  logic                cfg_en,
  input  logic [1:0]          cfg_mtype,
  input  logic                cfg_sel,
  input  logic                cfg_timing,
  input  logic                cfg_action,
  input  logic                cfg_chain,
  input  logic [DW-1:0]       cfg_value,
  input  logic                probe_valid,
  input  logic                probe_store,
  input  logic                probe_load,
  input  logic [DW-1:0]       probe_addr,
  input  logic [DW-1:0]       probe_data,
  input  logic                hit_clear,
  output logic [NUM_TRIG-1:0] hit_vec,
  output logic                any_hit,
  output logic                trap_next,
  output logic                trap_action
);

  trig_ctl_t                   wr_ctl;
  trig_ctl_t [NUM_TRIG-1:0]    ctl;
  logic [NUM_TRIG-1:0][DW-1:0] val;
  logic [NUM_PAIRS-1:0]        chain;
  logic [NUM_TRIG-1:0]         raw;
  logic [NUM_TRIG-1:0]         fire;
  logic [NUM_TRIG-1:0]         tim_vec;
  logic [NUM_TRIG-1:0]         act_vec;

  assign wr_ctl = '{en: cfg_en, mtype: match_kind_e'(cfg_mtype), sel: cfg_sel,
                    timing: cfg_timing, action: cfg_action};

  trig_bank #(.NUM_TRIG(NUM_TRIG), .NUM_PAIRS(NUM_PAIRS), .DW(DW), .IDXW(IDXW)) u_bank (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_ctl(wr_ctl),
    .cfg_chain(cfg_chain), .cfg_value(cfg_value),
    .ctl_o(ctl), .val_o(val), .chain_o(chain)
  );

  for (genvar k = 0; k < NUM_TRIG; k++) begin : g_cmp
    trig_cmp #(.DW(DW)) u_cmp (
      .ctl(ctl[k]), .value(val[k]), .addr(probe_addr), .data(probe_data),
      .valid(probe_valid), .is_load(probe_load), .hit(raw[k])
    );
    assign tim_vec[k] = ctl[k].timing;
    assign act_vec[k] = ctl[k].action;
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    trig_pair u_pair (
      .clk(clk), .rst(rst),
      .raw_a(raw[2*p]), .raw_b(raw[2*p+1]),
      .tim_a(tim_vec[2*p]), .tim_b(tim_vec[2*p+1]),
      .chain(chain[p]), .is_store(probe_store),
      .fire_a(fire[2*p]), .fire_b(fire[2*p+1])
    );
  end

  always_comb begin
    hit_vec     = hit_clear ? '0 : fire;
    any_hit     = |hit_vec;
    trap_next   = any_hit && ((hit_vec & ~tim_vec) == '0);
    trap_action = |(hit_vec & act_vec);
  end

  // R11: clear or no probe means silent outputs
  p_clear_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (hit_clear || !probe_valid) |-> (hit_vec == '0 && !any_hit && !trap_next && !trap_action));

  // R10: a next-instruction trap needs some hit
  p_next_needs_hit_r10: assert property (@(posedge clk) disable iff (rst)
    trap_next |-> any_hit);

  // R12: an action report needs some hit
  p_action_needs_hit_r12: assert property (@(posedge clk) disable iff (rst)
    trap_action |-> any_hit);

endmodule

// File: tb/trig_match_top_bench.sv
`timescale 1ns/100ps
module trig_match_top_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic        cfg_en = 1'b0;
  logic [1:0]  cfg_mtype = '0;
  logic        cfg_sel = 1'b0;
  logic        cfg_timing = 1'b0;
  logic        cfg_action = 1'b0;
  logic        cfg_chain = 1'b0;
  logic [63:0] cfg_value = '0;
  logic        probe_valid = 1'b0;
  logic        probe_store = 1'b0;
  logic        probe_load = 1'b0;
  logic [63:0] probe_addr = '0;
  logic [63:0] probe_data = '0;
  logic        hit_clear = 1'b0;
  logic [9:0]  hit_vec;
  logic        any_hit;
  logic        trap_next;
  logic        trap_action;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  trig_match_top u_trig_match_top (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
    .cfg_mtype(cfg_mtype), .cfg_sel(cfg_sel), .cfg_timing(cfg_timing),
    .cfg_action(cfg_action), .cfg_chain(cfg_chain), .cfg_value(cfg_value),
    .probe_valid(probe_valid), .probe_store(probe_store), .probe_load(probe_load),
    .probe_addr(probe_addr), .probe_data(probe_data), .hit_clear(hit_clear),
    .hit_vec(hit_vec), .any_hit(any_hit), .trap_next(trap_next), .trap_action(trap_action)
  );

  typedef struct packed {
    logic [1:0]  mt;
    logic        sel;
    logic [63:0] cmp;
    logic [63:0] addr;
    logic [63:0] data;
    logic        ld;
    logic        exp;
  } vec_t;

  localparam vec_t TBL [11] = '{
    '{2'd0, 1'b0, 64'h1000, 64'h1000, 64'h0,    1'b0, 1'b1},
    '{2'd0, 1'b0, 64'h1000, 64'h1001, 64'h0,    1'b0, 1'b0},
    '{2'd1, 1'b0, 64'h1003, 64'h1007, 64'h0,    1'b0, 1'b1},
    '{2'd1, 1'b0, 64'h1003, 64'h1008, 64'h0,    1'b0, 1'b0},
    '{2'd2, 1'b0, 64'h500,  64'h500,  64'h0,    1'b0, 1'b1},
    '{2'd2, 1'b0, 64'h500,  64'h4FF,  64'h0,    1'b0, 1'b0},
    '{2'd3, 1'b0, 64'h500,  64'h4FF,  64'h0,    1'b0, 1'b1},
    '{2'd3, 1'b0, 64'h500,  64'h500,  64'h0,    1'b0, 1'b0},
    '{2'd0, 1'b1, 64'hABCD, 64'h0,    64'hABCD, 1'b0, 1'b1},
    '{2'd0, 1'b1, 64'hABCD, 64'h0,    64'hABCD, 1'b1, 1'b0},
    '{2'd0, 1'b0, 64'hABCD, 64'h0,    64'hABCD, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input int idx, input logic en, input logic [1:0] mt, input logic sel,
                    input logic tim, input logic act, input logic ch, input logic [63:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_en = en; cfg_mtype = mt; cfg_sel = sel;
    cfg_timing = tim; cfg_action = act; cfg_chain = ch; cfg_value = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic probe(input logic [63:0] a, input logic [63:0] d,
                       input logic st, input logic ld);
    probe_valid = 1'b1; probe_addr = a; probe_data = d; probe_store = st; probe_load = ld;
    #1;
  endtask

  task automatic clear_all();
    for (int k = 0; k < 10; k++) wr(k, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: nothing enabled after reset
    probe(64'h0, 64'h0, 1'b0, 1'b0);
    chk("R1 hit_vec after reset", 16'(hit_vec), 16'h0);
    chk("R1 any_hit after reset", 16'(any_hit), 16'h0);

    // R3 R4 R8: table of single-trigger compares on trigger 0
    for (int i = 0; i < 11; i++) begin
      wr(0, 1'b1, TBL[i].mt, TBL[i].sel, 1'b0, 1'b0, 1'b0, TBL[i].cmp);
      probe(TBL[i].addr, TBL[i].data, 1'b0, TBL[i].ld);
      chk(i < 8 ? "R3 match kind" : (i == 9 ? "R8 load data" : "R4 select"),
          16'(hit_vec[0]), 16'(TBL[i].exp));
      chk("R9 any_hit follows vector", 16'(any_hit), 16'(TBL[i].exp));
    end

    // R3: all-ones region covers everything
    wr(0, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
    probe(64'h0123_4567_89AB_CDEF, 64'h0, 1'b0, 1'b0);
    chk("R3 full region", 16'(hit_vec), 16'h001);

    // R2: write lands only in indexed slot, out-of-range index ignored
    clear_all();
    wr(3, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h20);
    probe(64'h20, 64'h0, 1'b0, 1'b0);
    chk("R2 indexed write", 16'(hit_vec), 16'h008);
    wr(12, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h99);
    probe(64'h99, 64'h0, 1'b0, 1'b0);
    chk("R2 out-of-range write ignored", 16'(hit_vec), 16'h000);
    probe(64'h20, 64'h0, 1'b0, 1'b0);
    chk("R2 slot kept after ignored write", 16'(hit_vec), 16'h008);

    // R5: unchained pair fires independently
    clear_all();
    wr(4, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h40);
    wr(5, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h50);
    probe(64'h40, 64'h0, 1'b0, 1'b0);
    chk("R5 even alone", 16'(hit_vec), 16'h010);
    probe(64'h50, 64'h0, 1'b0, 1'b0);
    chk("R5 odd alone", 16'(hit_vec), 16'h020);

    // R6: chained pair needs both
    wr(4, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 64'h40);
    wr(5, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 64'h30);
    probe(64'h40, 64'h0, 1'b0, 1'b0);
    chk("R6 both match", 16'(hit_vec), 16'h030);
    probe(64'h50, 64'h0, 1'b0, 1'b0);
    chk("R6 one match", 16'(hit_vec), 16'h000);

    // R2: chain field on odd write discarded
    wr(6, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h60);
    wr(7, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 64'h70);
    probe(64'h70, 64'h0, 1'b0, 1'b0);
    chk("R2 odd chain ignored", 16'(hit_vec), 16'h080);

    // R8: stores silence chained pairs only
    probe(64'h40, 64'h0, 1'b1, 1'b0);
    chk("R8 store on chained pair", 16'(hit_vec), 16'h000);
    probe(64'h70, 64'h0, 1'b1, 1'b0);
    chk("R8 store on unchained pair", 16'(hit_vec), 16'h080);

    // R7: timing mismatch in chained pair
    wr(5, 1'b1, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 64'h30);
    probe(64'h40, 64'h0, 1'b0, 1'b0);
    chk("R7 timing mismatch", 16'(hit_vec), 16'h000);

    // R10 R12: timing and action reporting
    clear_all();
    wr(2, 1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 64'h80);
    probe(64'h80, 64'h0, 1'b0, 1'b0);
    chk("R9 single hit", 16'(hit_vec), 16'h004);
    chk("R10 next-only timing", 16'(trap_next), 16'h1);
    chk("R12 action set", 16'(trap_action), 16'h1);
    wr(9, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h80);
    probe(64'h80, 64'h0, 1'b0, 1'b0);
    chk("R9 two pairs hit", 16'(hit_vec), 16'h204);
    chk("R10 current wins", 16'(trap_next), 16'h0);
    chk("R12 action kept", 16'(trap_action), 16'h1);
    wr(2, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 64'h80);
    probe(64'h80, 64'h0, 1'b0, 1'b0);
    chk("R12 action clear", 16'(trap_action), 16'h0);
    wr(2, 1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 64'h80);

    // R11: clear and no-probe
    hit_clear = 1'b1;
    probe(64'h80, 64'h0, 1'b0, 1'b0);
    chk("R11 clear vector", 16'(hit_vec), 16'h000);
    chk("R11 clear flags", 16'({any_hit, trap_next, trap_action}), 16'h0);
    hit_clear = 1'b0;
    probe_valid = 1'b0;
    #1;
    chk("R11 no probe", 16'(hit_vec), 16'h000);
    probe(64'h80, 64'h0, 1'b0, 1'b0);
    chk("R11 release", 16'(hit_vec), 16'h204);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule